// File: doc/BRIEF.md
# Prescaled Pacing Timer Bank

This block holds three down-counting timers that share one oscillator clock and are reached through a small register port. Each timer has its own fixed prescale ratio. Timer 0 and timer 1 are 16 bits wide. Timer 2 is 24 bits wide. Each timer runs in one of four counting modes. A gate bit lets it count or holds its count. Each timer drives an output line that paces downstream logic, such as conversion starts or scan starts.

Timer 2 is the flexible one. It can count the prescaled oscillator, the terminal events of timer 1, or two external event strobes (end of conversion and end of scan). Its terminal count sets a sticky flag, which can raise an interrupt or, in watchdog role, a trip output. Its 24-bit count passes through the 16-bit data port as two halves. A select register chooses the half, and a read of the select register clears the sticky flag.

Register addresses on `bus_addr`:

| Address | Access | Fields |
|---|---|---|
| 0 | read/write | control: bit 12+x is the gate of timer x |
| 1 | read | status: bit 12 is the sticky flag |
| 2 | read/write | data port |
| 3 | read/write | select: bits 1:0 pick the target, bits 7:4 drive `dig_out`; a read clears the flag |
| 4 | read/write | modes: bits 2x+1:2x hold the mode code of timer x |
| 5 | read/write | timer 2 setup: bits 7:6 clock source, bits 5:4 role, bit 2 interrupt enable |

Top module: `pace_timer_bank`

## Requirements
- R1: Each timer advances once per prescaled tick: timer 0 every PRE0 clocks, timer 1 every PRE1 clocks, and timer 2 (clock source 0) every PRE2 clocks. A divisor d therefore gives a period of d times the prescale ratio.
- R2: Mode code 1 (rate generator) reloads the divisor whenever the count reaches 1. The timer output gives a one-clock pulse once per period, with no end.
- R3: A loaded divisor of 0 or 1 acts as a divisor of 2.
- R4: Mode code 2 (software strobe): each write of the count starts one countdown. Its terminal count gives exactly one output pulse, and the timer then stops.
- R5: Mode code 0 (interrupt on terminal count): the output rises at the terminal count and stays high until the next count write, which clears it.
- R6: Mode code 3 (hardware strobe): a count write loads the timer but does not start it. A high cycle on the timer's `strobe_trig` bit starts one countdown, which ends with exactly one output pulse.
- R7: Gate bit 12+x of the control register (address 0) enables timer x. With the gate clear, the count holds its value. Setting the gate again resumes counting from that held value.
- R8: The mode register (address 4) holds the 2-bit mode code of timer x at bits 2x+1:2x.
- R9: The data port (address 2) reaches the timer picked by select bits 1:0. Index 0 and index 1 load and read timers 0 and 1. Index 2 reads timer 2 bits 15:0 and stages the low half on a write. Index 3 reads timer 2 bits 23:16, and a write there loads the whole 24-bit count.
- R10: Select bits 7:4 drive `dig_out` and change only on a write to address 3.
- R11: Timer 2 takes its clock from setup bits 7:6: 0 is the prescaled oscillator, 1 is timer 1's terminal event, 2 is `eoc_evt` and 3 is `eos_evt`.
- R12: Timer 2's terminal count sets a sticky flag, seen at status bit 12. A read of the select register clears it. `irq` is high while the flag is set and setup bit 2 is 1.
- R13: With role code 2 (watchdog) in setup bits 5:4, `wdog_trip` follows the sticky flag. Role codes 0 (timer) and 1 (event counter) keep it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| eoc_evt | input | 1 | End-of-conversion event, clock source 2 of timer 2 |
| eos_evt | input | 1 | End-of-scan event, clock source 3 of timer 2 |
| strobe_trig | input | 3 | Per-timer start for hardware-strobe mode |
| tmr_out | output | 3 | Timer output lines |
| dig_out | output | 4 | Digital outputs from select bits 7:4 |
| irq | output | 1 | Timer 2 interrupt |
| wdog_trip | output | 1 | Timer 2 watchdog expiry |

## Verification
The bench builds the block with prescale ratios of 2, 4 and 3 in place of 10, 1000 and 1000. With these ratios many full periods, one-shot windows and timer 2 cascades fit into a short run, and each measured period still separates the three ratios. The counter widths keep their defaults of 16 and 24 bits. As a result, the split access to timer 2 crosses a real borrow from the upper half, and a count of 0x120005 can be held, read back and resumed.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [1:0] {
        TM_TC_LEVEL  = 2'd0,
        TM_RATE      = 2'd1,
        TM_SW_STROBE = 2'd2,
        TM_HW_STROBE = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        CS_OSC  = 2'd0,
        CS_TMR1 = 2'd1,
        CS_EOC  = 2'd2,
        CS_EOS  = 2'd3
    } clksrc_e;

    localparam logic [1:0] ROLE_WDOG = 2'd2;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_DATA  = 3'd2;
    localparam logic [2:0] A_SEL   = 3'd3;
    localparam logic [2:0] A_TMODE = 3'd4;
    localparam logic [2:0] A_T2CFG = 3'd5;

    localparam int PORT_W = 16;
endpackage

// File: rtl/pt_prescale.sv
module pt_prescale #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/pt_counter.sv
module pt_counter
    import pt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         gate,
    input  tmode_e       mode,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         trig,
    output logic [W-1:0] cnt_o,
    output logic         out_o,
    output logic         tc_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic         run;
        logic         out;
    } cstate_t;

    cstate_t s_d, s_q;
    logic [W-1:0] eff;
    logic tc;

    assign eff = (load_val < W'(2)) ? W'(2) : load_val;
    assign tc  = s_q.run && gate && tick && (s_q.cnt == W'(1));

    always_comb begin
        s_d = s_q;
        s_d.out = (mode == TM_TC_LEVEL) ? s_q.out : 1'b0;
        if (tc) begin
            s_d.cnt = (mode == TM_RATE) ? s_q.rld : '0;
            s_d.run = (mode == TM_RATE);
            s_d.out = 1'b1;
        end else if (s_q.run && gate && tick) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (load) begin
            s_d.rld = eff;
            s_d.cnt = eff;
            s_d.run = (mode != TM_HW_STROBE);
            s_d.out = 1'b0;
        end else if (trig && mode == TM_HW_STROBE && s_q.rld != '0) begin
            s_d.cnt = s_q.rld;
            s_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign out_o = s_q.out;
    assign tc_o  = tc;

    // R3: a running count never sits at zero
    a_r3_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.cnt != '0));
    // R7: gate low holds the count
    a_r7_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !load && !trig) |=> $stable(s_q.cnt));
    // R4: one-shot modes stop after the terminal count
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode != TM_RATE && !load && !trig) |=> !s_q.run);
    // R2: rate mode keeps running through the terminal count
    a_r2_rate_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode == TM_RATE && !load) |=> s_q.run);
endmodule

// File: rtl/pace_timer_bank.sv
module pace_timer_bank
    import pt_pkg::*;
#(
    parameter int PRE0  = 10,
    parameter int PRE1  = 1000,
    parameter int PRE2  = 1000,
    parameter int T01_W = 16,
    parameter int T2_W  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        eoc_evt,
    input  logic        eos_evt,
    input  logic [2:0]  strobe_trig,
    output logic [2:0]  tmr_out,
    output logic [3:0]  dig_out,
    output logic        irq,
    output logic        wdog_trip
);
    localparam int HI_W = T2_W - PORT_W;

    typedef struct packed {
        logic [2:0]        gate;
        logic [7:0]        sel;
        logic [5:0]        tmode;
        logic [1:0]        t2clk;
        logic [1:0]        t2role;
        logic              t2irq;
        logic [PORT_W-1:0] stage;
        logic              flag;
    } regs_t;

    regs_t r_d, r_q;

    logic             data_wr, sel_rd;
    logic [1:0]       idx;
    logic [1:0]       tc01;
    logic [T01_W-1:0] cnt01 [2];
    logic [T2_W-1:0]  cnt2;
    logic             tc2, tick2, load2;
    logic [T2_W-1:0]  load2_val;
    logic [2:0]       pre_tick;

    assign idx     = r_q.sel[1:0];
    assign data_wr = bus_wr && (bus_addr == A_DATA);
    assign sel_rd  = bus_rd && (bus_addr == A_SEL);

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  r_d.gate  = bus_wdata[14:12];
                A_SEL:   r_d.sel   = bus_wdata[7:0];
                A_TMODE: r_d.tmode = bus_wdata[5:0];
                A_T2CFG: begin
                    r_d.t2clk  = bus_wdata[7:6];
                    r_d.t2role = bus_wdata[5:4];
                    r_d.t2irq  = bus_wdata[2];
                end
                A_DATA:  if (idx == 2'd2) r_d.stage = bus_wdata;
                default: ;
            endcase
        end
        if (sel_rd) r_d.flag = 1'b0;
        if (tc2)    r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    genvar i;
    generate
        for (i = 0; i < 3; i++) begin : g_pre
            pt_prescale #(.DIV((i == 0) ? PRE0 : ((i == 1) ? PRE1 : PRE2))) u_pre (
                .clk(clk), .rst_n(rst_n), .tick(pre_tick[i]));
        end
        for (i = 0; i < 2; i++) begin : g_t01
            pt_counter #(.W(T01_W)) u_cnt (
                .clk(clk), .rst_n(rst_n),
                .tick(pre_tick[i]),
                .gate(r_q.gate[i]),
                .mode(tmode_e'(r_q.tmode[2*i +: 2])),
                .load(data_wr && idx == 2'(i)),
                .load_val(T01_W'(bus_wdata)),
                .trig(strobe_trig[i]),
                .cnt_o(cnt01[i]),
                .out_o(tmr_out[i]),
                .tc_o(tc01[i]));
        end
    endgenerate

    always_comb begin
        case (clksrc_e'(r_q.t2clk))
            CS_OSC:  tick2 = pre_tick[2];
            CS_TMR1: tick2 = tc01[1];
            CS_EOC:  tick2 = eoc_evt;
            default: tick2 = eos_evt;
        endcase
    end

    assign load2     = data_wr && (idx == 2'd3);
    assign load2_val = {bus_wdata[HI_W-1:0], r_q.stage};

    pt_counter #(.W(T2_W)) u_t2 (
        .clk(clk), .rst_n(rst_n),
        .tick(tick2),
        .gate(r_q.gate[2]),
        .mode(tmode_e'(r_q.tmode[5:4])),
        .load(load2),
        .load_val(load2_val),
        .trig(strobe_trig[2]),
        .cnt_o(cnt2),
        .out_o(tmr_out[2]),
        .tc_o(tc2));

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[14:12] = r_q.gate;
            A_STAT:  bus_rdata[12]    = r_q.flag;
            A_SEL:   bus_rdata[7:0]   = r_q.sel;
            A_TMODE: bus_rdata[5:0]   = r_q.tmode;
            A_T2CFG: bus_rdata[7:0]   = {r_q.t2clk, r_q.t2role, 1'b0, r_q.t2irq, 2'b00};
            A_DATA: begin
                case (idx)
                    2'd0:    bus_rdata = PORT_W'(cnt01[0]);
                    2'd1:    bus_rdata = PORT_W'(cnt01[1]);
                    2'd2:    bus_rdata = cnt2[PORT_W-1:0];
                    default: bus_rdata = PORT_W'(cnt2[T2_W-1:PORT_W]);
                endcase
            end
            default: ;
        endcase
    end

    assign dig_out   = r_q.sel[7:4];
    assign irq       = r_q.flag && r_q.t2irq;
    assign wdog_trip = r_q.flag && (r_q.t2role == ROLE_WDOG);

    // R12: timer 2 terminal count sets the sticky flag
    a_r12_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tc2 |=> r_q.flag);
    // R12: a select read clears the flag unless a new terminal count coincides
    a_r12_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rd && !tc2) |=> !r_q.flag);
    // R10: digital outputs move only on a select write
    a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_SEL) |=> $stable(dig_out));
endmodule

// File: tb/pace_timer_bank_tb_top.sv
module pace_timer_bank_tb_top;
    localparam int P0 = 2;
    localparam int P1 = 4;
    localparam int P2 = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        eoc_evt = 1'b0, eos_evt = 1'b0;
    logic [2:0]  strobe_trig = '0;
    logic [2:0]  tmr_out;
    logic [3:0]  dig_out;
    logic        irq, wdog_trip;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pace_timer_bank #(.PRE0(P0), .PRE1(P1), .PRE2(P2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eoc_evt(eoc_evt), .eos_evt(eos_evt), .strobe_trig(strobe_trig),
        .tmr_out(tmr_out), .dig_out(dig_out), .irq(irq), .wdog_trip(wdog_trip));

    function automatic int exp_period(int d, int p);
        return ((d < 2) ? 2 : d) * p;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(string req, longint act, longint lo, longint hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_pulse(int idx, int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tmr_out[idx] && n < maxc);
    endtask

    task automatic count_pulses(int idx, int cyc, output int n);
        n = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (tmr_out[idx]) n++;
        end
    endtask

    task automatic read_t2(output logic [23:0] v);
        logic [15:0] hi, lo;
        wr(3'd3, 16'h0003);
        rd(3'd2, hi);
        wr(3'd3, 16'h0002);
        rd(3'd2, lo);
        v = {hi[7:0], lo};
    endtask

    task automatic pulse_evt(bit use_eoc, int times);
        for (int k = 0; k < times; k++) begin
            @(negedge clk);
            if (use_eoc) eoc_evt = 1'b1; else eos_evt = 1'b1;
            @(negedge clk);
            eoc_evt = 1'b0; eos_evt = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [23:0] f0, f1, f2, f3;
        int n;
        int d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(3'd1, v);
        chk("R12 reset status", v, 0);
        chk("R2 reset outputs", tmr_out, 0);
        chk("R10 reset dig_out", dig_out, 0);
        chk("R12 reset irq", irq, 0);

        // R10
        wr(3'd3, 16'h00A0);
        chk("R10 dig_out", dig_out, 4'hA);
        rd(3'd3, v);
        chk("R10 select readback", v, 16'h00A0);

        // R1 R2 R8: timer0 rate generator
        wr(3'd4, 16'h0001);
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'd5);
        wr(3'd0, 16'h1000);
        wait_pulse(0, 200, n);
        wait_pulse(0, 200, n);
        chk("R1 R2 timer0 period", n, exp_period(5, P0));
        @(negedge clk);
        chk("R2 pulse width one clock", tmr_out[0], 0);

        // R1 R2 random divisors
        for (int k = 0; k < 6; k++) begin
            d = 2 + int'($urandom % 15);
            wr(3'd2, 16'(d));
            wait_pulse(0, 200, n);
            wait_pulse(0, 200, n);
            chk("R2 random divisor period", n, exp_period(d, P0));
        end

        // R3: 0 and 1 act as 2
        wr(3'd2, 16'd0);
        wait_pulse(0, 200, n);
        wait_pulse(0, 200, n);
        chk("R3 divisor 0", n, exp_period(0, P0));
        wr(3'd2, 16'd1);
        wait_pulse(0, 200, n);
        wait_pulse(0, 200, n);
        chk("R3 divisor 1", n, exp_period(1, P0));

        // R8 R1: timer1 rate via bits 3:2
        wr(3'd4, 16'h0005);
        wr(3'd3, 16'h0001);
        wr(3'd2, 16'd3);
        wr(3'd0, 16'h3000);
        wait_pulse(1, 200, n);
        wait_pulse(1, 200, n);
        chk("R8 R1 timer1 period", n, exp_period(3, P1));

        // R4: software strobe on timer0
        wr(3'd4, 16'h0006);
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'd4);
        count_pulses(0, 60, n);
        chk("R4 single strobe pulse", n, 1);
        wr(3'd2, 16'd4);
        count_pulses(0, 60, n);
        chk("R4 rewrite restarts strobe", n, 1);

        // R5: mode 0 level
        wr(3'd4, 16'h0004);
        wr(3'd2, 16'd3);
        chk("R5 load clears output", tmr_out[0], 0);
        repeat (30) @(negedge clk);
        chk("R5 output high after tc", tmr_out[0], 1);
        repeat (10) @(negedge clk);
        chk("R5 output stays high", tmr_out[0], 1);
        wr(3'd2, 16'd3);
        chk("R5 write clears output", tmr_out[0], 0);

        // R6: hardware strobe
        wr(3'd4, 16'h0007);
        wr(3'd2, 16'd3);
        count_pulses(0, 40, n);
        chk("R6 load does not start", n, 0);
        @(negedge clk);
        strobe_trig[0] = 1'b1;
        @(negedge clk);
        strobe_trig[0] = 1'b0;
        count_pulses(0, 40, n);
        chk("R6 trigger gives one pulse", n, 1);

        // R9 R7: 24-bit load, readback, freeze and resume
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h0002);
        wr(3'd2, 16'h0005);
        wr(3'd3, 16'h0003);
        wr(3'd2, 16'h0012);
        read_t2(f0);
        chk("R9 24-bit readback", f0, 24'h120005);
        wr(3'd0, 16'h4000);
        repeat (30) @(negedge clk);
        wr(3'd0, 16'h0000);
        read_t2(f1);
        chk_range("R7 counted while gated", longint'(f0) - longint'(f1), 9, 13);
        repeat (20) @(negedge clk);
        read_t2(f2);
        chk("R7 frozen with gate clear", f2, f1);
        wr(3'd0, 16'h4000);
        repeat (30) @(negedge clk);
        wr(3'd0, 16'h0000);
        read_t2(f3);
        chk_range("R7 resumed from held value", longint'(f2) - longint'(f3), 9, 13);

        // R11 R12: eoc clock source, flag and irq
        wr(3'd5, 16'h0084);
        wr(3'd3, 16'h0002);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'h0003);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h4000);
        pulse_evt(1'b0, 5);
        rd(3'd1, v);
        chk("R11 eos ignored when source is eoc", v[12], 0);
        pulse_evt(1'b1, 2);
        rd(3'd1, v);
        chk("R11 two eoc not yet terminal", v[12], 0);
        pulse_evt(1'b1, 1);
        repeat (2) @(negedge clk);
        rd(3'd1, v);
        chk("R12 flag set at terminal", v[12], 1);
        chk("R12 irq with enable", irq, 1);
        repeat (20) @(negedge clk);
        rd(3'd1, v);
        chk("R12 flag sticky", v[12], 1);
        chk("R13 no trip in timer role", wdog_trip, 0);
        rd(3'd3, v);
        rd(3'd1, v);
        chk("R12 select read clears flag", v[12], 0);
        chk("R12 irq cleared", irq, 0);

        // R11: timer1 as clock for timer2
        wr(3'd5, 16'h0044);
        wr(3'd3, 16'h0002);
        wr(3'd2, 16'd2);
        wr(3'd3, 16'h0003);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h6000);
        repeat (4) @(negedge clk);
        chk("R11 cascade not early", irq, 0);
        repeat (60) @(negedge clk);
        chk("R11 cascade from timer1", irq, 1);
        rd(3'd3, v);

        // R13: watchdog role
        wr(3'd5, 16'h0020);
        wr(3'd3, 16'h0002);
        wr(3'd2, 16'd2);
        wr(3'd3, 16'h0003);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h4000);
        repeat (30) @(negedge clk);
        chk("R13 watchdog trip", wdog_trip, 1);
        chk("R12 irq masked", irq, 0);
        rd(3'd3, v);
        @(negedge clk);
        chk("R13 trip cleared", wdog_trip, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule